// File: doc/BRIEF.md
# Ethernet DMA Descriptor Ring Walker

This block drives the descriptor side of an Ethernet DMA engine. It keeps a transmit ring and a receive ring in a shared word memory, where each descriptor occupies a 16-byte slot. It reaches that memory through one request port whose read data returns a fixed number of cycles after the request. An arbiter shares the port between a transmit engine and a receive engine. While a read is in flight, the arbiter issues no other access.

The transmit engine starts on a one-cycle start pulse. It fetches the current descriptor and hands the buffer address and frame length to a frame-sender handshake. It then writes the control word back with ownership removed, and repeats this until it meets a descriptor it does not own. At that point it drops its run flag and waits for software to start it again.

The receive engine runs only while its enable is high. When a frame is pending from the receive stub, it claims the current owned descriptor. It records the frame length, clipped to the buffer size, and flags errors. It then returns the descriptor to software and pulses a completion report. Each ring has a base address and a last-slot address, and these are held on configuration inputs before the engines start.

Top module: `eth_desc_walker`

## Requirements
- R1: A transmit descriptor is processed only if bit 31 (ownership) of its control word (offset +0) is set. If the bit is clear, `tx_run_o` falls, and the engine makes no further memory access until the next start.
- R2: For an owned transmit descriptor, `tx_frm_valid_o` presents the word at offset +8 as the buffer address and bits 31:16 of the word at offset +4 as the length. These values stay stable until `tx_frm_ready_i` is seen.
- R3: After the sender handshake, the transmit control word is written back with bit 31 cleared and every other bit unchanged, including the end-of-list bit 30.
- R4: After a descriptor completes, the next descriptor address is the current address plus 16. It is the ring base instead when bit 30 of the control word is set or when the current address equals the ring's last-slot address.
- R5: A one-cycle `tx_start_i` pulse while idle raises `tx_run_o`, and only the engine itself clears it. The first start after reset begins at the transmit base. A later start resumes at the descriptor that stopped the engine.
- R6: While `rx_en_i` is low, the receive engine accepts no frame and makes no memory access.
- R7: Receive write-back stores the frame length in bits 15:0 of the word at offset +4 and keeps the buffer size in bits 31:16. A length larger than the buffer size is stored as the buffer size.
- R8: The receive control word is written back with bit 31 cleared and bit 27 set when the frame had an input error or overflowed its buffer. Bit 27 is cleared otherwise, and all other bits are kept.
- R9: If the current receive descriptor is not owned, the pending frame is not accepted, nothing is written, and the engine retries until the descriptor becomes owned.
- R10: After each receive write-back, `rx_done_o` pulses for exactly one cycle with the stored length on `rx_len_o` and the error flag on `rx_err_o`.
- R11: The memory port carries at most one access per cycle and issues nothing while a read is waiting for its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_base_i | input | AW | Transmit ring base byte address |
| tx_last_i | input | AW | Byte address of the last transmit slot |
| tx_start_i | input | 1 | One-cycle request to start transmission |
| tx_run_o | output | 1 | Transmit engine running |
| tx_frm_valid_o | output | 1 | Frame offered to the sender |
| tx_frm_addr_o | output | 32 | Buffer address of the offered frame |
| tx_frm_len_o | output | 16 | Length of the offered frame |
| tx_frm_ready_i | input | 1 | Sender accepts the offered frame |
| rx_base_i | input | AW | Receive ring base byte address |
| rx_last_i | input | AW | Byte address of the last receive slot |
| rx_en_i | input | 1 | Receive enable |
| rx_frm_valid_i | input | 1 | A received frame is pending |
| rx_frm_len_i | input | 16 | Length of the pending frame |
| rx_frm_err_i | input | 1 | Pending frame is bad |
| rx_frm_ready_o | output | 1 | Pending frame is taken this cycle |
| rx_done_o | output | 1 | Receive descriptor returned |
| rx_len_o | output | 16 | Stored length of the returned descriptor |
| rx_err_o | output | 1 | Error flag of the returned descriptor |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Byte address of the access |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid MEM_LAT cycles after the read |

## Verification
The bench uses a ring whose third slot carries end-of-list, with a fourth owned slot after it. A walker that ignored the flag would transmit that fourth frame and clear its ownership. It also moves the last-slot address onto an unflagged descriptor; a design that wrapped only on the flag would run on past the intended end. A restart after a stop must resume at the descriptor that was not owned, not at the base.

On the receive side, it sends an oversized frame, an input-error frame, and a clean frame into a descriptor whose stale error bit is set. These catch missing clipping and a sticky error bit. It also holds a frame against an unowned descriptor; a design that accepted or wrote anyway shows up in the memory image.

// File: rtl/eth_desc_pkg.sv
package eth_desc_pkg;
  localparam int DW       = 32;
  localparam int OWN_BIT  = 31;
  localparam int EOL_BIT  = 30;
  localparam int ERR_BIT  = 27;
  localparam int STRIDE   = 16;
  localparam logic [DW-1:0] OWN_M = 32'h1 << OWN_BIT;
  localparam logic [DW-1:0] ERR_M = 32'h1 << ERR_BIT;

  typedef enum logic [2:0] {T_IDLE, T_RD0, T_RD1, T_RD2, T_SEND, T_WB} tx_st_e;
  typedef enum logic [2:0] {R_IDLE, R_RD0, R_RD1, R_ACC, R_WB1, R_WB0} rx_st_e;
endpackage

// File: rtl/eth_desc_arb.sv
module eth_desc_arb #(
  parameter int NREQ = 2,
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int LAT  = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NREQ-1:0]          req_i,
  input  logic [NREQ-1:0]          we_i,
  input  logic [NREQ-1:0][AW-1:0]  addr_i,
  input  logic [NREQ-1:0][DW-1:0]  wdata_i,
  output logic [NREQ-1:0]          gnt_o,
  output logic [NREQ-1:0]          rvalid_o,
  output logic                     mem_req_o,
  output logic                     mem_we_o,
  output logic [AW-1:0]            mem_addr_o,
  output logic [DW-1:0]            mem_wdata_o
);
  localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1;
  localparam int CW = $clog2(LAT + 1);

  logic [IW-1:0] sel, owner_q;
  logic [CW-1:0] cnt_q;
  logic          any;

  // lowest index wins
  always_comb begin
    sel = '0;
    any = 1'b0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        sel = IW'(i);
        any = 1'b1;
      end
    end
  end

  assign mem_req_o   = any && (cnt_q == '0);
  assign mem_we_o    = we_i[sel];
  assign mem_addr_o  = addr_i[sel];
  assign mem_wdata_o = wdata_i[sel];

  for (genvar g = 0; g < NREQ; g++) begin : g_port
    assign gnt_o[g]    = mem_req_o && (sel == IW'(g));
    assign rvalid_o[g] = (cnt_q == CW'(1)) && (owner_q == IW'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      owner_q <= '0;
    end else if (mem_req_o && !mem_we_o) begin
      cnt_q   <= CW'(LAT);
      owner_q <= sel;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  p_one_grant_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  p_read_blocks_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> !mem_req_o);
  p_one_return_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rvalid_o));
endmodule

// File: rtl/eth_desc_tx.sv
module eth_desc_tx
  import eth_desc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] last_i,
  output logic          run_o,
  output logic          mreq_o,
  output logic          mwe_o,
  output logic [AW-1:0] maddr_o,
  output logic [DW-1:0] mwdata_o,
  input  logic          gnt_i,
  input  logic          rvalid_i,
  input  logic [DW-1:0] rdata_i,
  output logic          frm_valid_o,
  output logic [DW-1:0] frm_addr_o,
  output logic [15:0]   frm_len_o,
  input  logic          frm_ready_i
);
  tx_st_e        st_q;
  logic          run_q, primed_q, wait_q;
  logic [AW-1:0] cur_q, next_addr;
  logic [DW-1:0] w0_q, buf_q;
  logic [15:0]   len_q;

  assign next_addr   = (w0_q[EOL_BIT] || cur_q == last_i) ? base_i : cur_q + AW'(STRIDE);
  assign run_o       = run_q;
  assign frm_valid_o = (st_q == T_SEND);
  assign frm_addr_o  = buf_q;
  assign frm_len_o   = len_q;

  always_comb begin
    mreq_o   = 1'b0;
    mwe_o    = 1'b0;
    maddr_o  = cur_q;
    mwdata_o = w0_q & ~OWN_M;
    case (st_q)
      T_RD0: mreq_o = !wait_q;
      T_RD1: begin mreq_o = !wait_q; maddr_o = cur_q + AW'(4); end
      T_RD2: begin mreq_o = !wait_q; maddr_o = cur_q + AW'(8); end
      T_WB:  begin mreq_o = 1'b1; mwe_o = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= T_IDLE;
      run_q    <= 1'b0;
      primed_q <= 1'b0;
      wait_q   <= 1'b0;
      cur_q    <= '0;
      w0_q     <= '0;
      buf_q    <= '0;
      len_q    <= '0;
    end else begin
      case (st_q)
        T_IDLE: if (start_i) begin
          run_q <= 1'b1;
          st_q  <= T_RD0;
          if (!primed_q) begin
            cur_q    <= base_i;
            primed_q <= 1'b1;
          end
        end
        T_RD0, T_RD1, T_RD2: begin
          if (gnt_i) wait_q <= 1'b1;
          if (rvalid_i) begin
            wait_q <= 1'b0;
            case (st_q)
              T_RD0: begin
                w0_q <= rdata_i;
                if (!rdata_i[OWN_BIT]) begin
                  run_q <= 1'b0;
                  st_q  <= T_IDLE;
                end else st_q <= T_RD1;
              end
              T_RD1: begin len_q <= rdata_i[31:16]; st_q <= T_RD2; end
              default: begin buf_q <= rdata_i; st_q <= T_SEND; end
            endcase
          end
        end
        T_SEND: if (frm_ready_i) st_q <= T_WB;
        T_WB: if (gnt_i) begin
          cur_q <= next_addr;
          st_q  <= T_RD0;
        end
        default: st_q <= T_IDLE;
      endcase
    end
  end

  p_frame_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_valid_o && !frm_ready_i) |=> (frm_valid_o && $stable(frm_addr_o) && $stable(frm_len_o)));
  p_quiet_when_stopped_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !mreq_o);
  p_stop_cause_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_q) |-> ($past(rvalid_i) && !$past(rdata_i[OWN_BIT])));
endmodule

// File: rtl/eth_desc_rx.sv
module eth_desc_rx
  import eth_desc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] last_i,
  output logic          mreq_o,
  output logic          mwe_o,
  output logic [AW-1:0] maddr_o,
  output logic [DW-1:0] mwdata_o,
  input  logic          gnt_i,
  input  logic          rvalid_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          frm_valid_i,
  input  logic [15:0]   frm_len_i,
  input  logic          frm_err_i,
  output logic          frm_ready_o,
  output logic          done_o,
  output logic [15:0]   len_o,
  output logic          err_o
);
  rx_st_e        st_q;
  logic          primed_q, wait_q, err_q, done_q, err_o_q;
  logic [AW-1:0] cur_q, next_addr;
  logic [DW-1:0] w0_q;
  logic [15:0]   bsize_q, len_q, len_o_q;
  logic          over;

  assign next_addr   = (w0_q[EOL_BIT] || cur_q == last_i) ? base_i : cur_q + AW'(STRIDE);
  assign over        = frm_len_i > bsize_q;
  assign frm_ready_o = (st_q == R_ACC) && frm_valid_i;
  assign done_o      = done_q;
  assign len_o       = len_o_q;
  assign err_o       = err_o_q;

  always_comb begin
    mreq_o   = 1'b0;
    mwe_o    = 1'b0;
    maddr_o  = cur_q;
    mwdata_o = (w0_q & ~OWN_M & ~ERR_M) | (err_q ? ERR_M : '0);
    case (st_q)
      R_RD0: mreq_o = !wait_q;
      R_RD1: begin mreq_o = !wait_q; maddr_o = cur_q + AW'(4); end
      R_WB1: begin
        mreq_o   = 1'b1;
        mwe_o    = 1'b1;
        maddr_o  = cur_q + AW'(4);
        mwdata_o = {bsize_q, len_q};
      end
      R_WB0: begin mreq_o = 1'b1; mwe_o = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= R_IDLE;
      primed_q <= 1'b0;
      wait_q   <= 1'b0;
      cur_q    <= '0;
      w0_q     <= '0;
      bsize_q  <= '0;
      len_q    <= '0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
      len_o_q  <= '0;
      err_o_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        R_IDLE: if (en_i && frm_valid_i) begin
          st_q <= R_RD0;
          if (!primed_q) begin
            cur_q    <= base_i;
            primed_q <= 1'b1;
          end
        end
        R_RD0, R_RD1: begin
          if (gnt_i) wait_q <= 1'b1;
          if (rvalid_i) begin
            wait_q <= 1'b0;
            if (st_q == R_RD0) begin
              w0_q <= rdata_i;
              st_q <= rdata_i[OWN_BIT] ? R_RD1 : R_IDLE;
            end else begin
              bsize_q <= rdata_i[31:16];
              st_q    <= R_ACC;
            end
          end
        end
        R_ACC: if (frm_valid_i) begin
          len_q <= over ? bsize_q : frm_len_i;
          err_q <= frm_err_i || over;
          st_q  <= R_WB1;
        end else st_q <= R_IDLE;
        R_WB1: if (gnt_i) st_q <= R_WB0;
        R_WB0: if (gnt_i) begin
          done_q  <= 1'b1;
          len_o_q <= len_q;
          err_o_q <= err_q;
          cur_q   <= next_addr;
          st_q    <= R_IDLE;
        end
        default: st_q <= R_IDLE;
      endcase
    end
  end

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_len_fits_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (len_o_q <= bsize_q));
  p_stay_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == R_IDLE && !en_i) |=> (st_q == R_IDLE && !mreq_o));
endmodule

// File: rtl/eth_desc_walker.sv
module eth_desc_walker
  import eth_desc_pkg::*;
#(
  parameter int AW      = 16,
  parameter int MEM_LAT = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] tx_base_i,
  input  logic [AW-1:0] tx_last_i,
  input  logic          tx_start_i,
  output logic          tx_run_o,
  output logic          tx_frm_valid_o,
  output logic [31:0]   tx_frm_addr_o,
  output logic [15:0]   tx_frm_len_o,
  input  logic          tx_frm_ready_i,
  input  logic [AW-1:0] rx_base_i,
  input  logic [AW-1:0] rx_last_i,
  input  logic          rx_en_i,
  input  logic          rx_frm_valid_i,
  input  logic [15:0]   rx_frm_len_i,
  input  logic          rx_frm_err_i,
  output logic          rx_frm_ready_o,
  output logic          rx_done_o,
  output logic [15:0]   rx_len_o,
  output logic          rx_err_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i
);
  localparam int NREQ = 2;

  logic [NREQ-1:0]         req, we, gnt, rvalid;
  logic [NREQ-1:0][AW-1:0] addr;
  logic [NREQ-1:0][DW-1:0] wdata;

  eth_desc_tx #(.AW(AW)) u_tx (
    .clk_i, .rst_ni,
    .start_i     (tx_start_i),
    .base_i      (tx_base_i),
    .last_i      (tx_last_i),
    .run_o       (tx_run_o),
    .mreq_o      (req[0]),
    .mwe_o       (we[0]),
    .maddr_o     (addr[0]),
    .mwdata_o    (wdata[0]),
    .gnt_i       (gnt[0]),
    .rvalid_i    (rvalid[0]),
    .rdata_i     (mem_rdata_i),
    .frm_valid_o (tx_frm_valid_o),
    .frm_addr_o  (tx_frm_addr_o),
    .frm_len_o   (tx_frm_len_o),
    .frm_ready_i (tx_frm_ready_i)
  );

  eth_desc_rx #(.AW(AW)) u_rx (
    .clk_i, .rst_ni,
    .en_i        (rx_en_i),
    .base_i      (rx_base_i),
    .last_i      (rx_last_i),
    .mreq_o      (req[1]),
    .mwe_o       (we[1]),
    .maddr_o     (addr[1]),
    .mwdata_o    (wdata[1]),
    .gnt_i       (gnt[1]),
    .rvalid_i    (rvalid[1]),
    .rdata_i     (mem_rdata_i),
    .frm_valid_i (rx_frm_valid_i),
    .frm_len_i   (rx_frm_len_i),
    .frm_err_i   (rx_frm_err_i),
    .frm_ready_o (rx_frm_ready_o),
    .done_o      (rx_done_o),
    .len_o       (rx_len_o),
    .err_o       (rx_err_o)
  );

  eth_desc_arb #(.NREQ(NREQ), .AW(AW), .DW(DW), .LAT(MEM_LAT)) u_arb (
    .clk_i, .rst_ni,
    .req_i       (req),
    .we_i        (we),
    .addr_i      (addr),
    .wdata_i     (wdata),
    .gnt_o       (gnt),
    .rvalid_o    (rvalid),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
  );
endmodule

// File: tb/eth_desc_walker_test.sv
module eth_desc_walker_test;
  localparam int AW  = 16;
  localparam int LAT = 2;

  typedef struct packed {
    logic [31:0] ctrl;
    logic [15:0] len;
    logic [31:0] addr;
  } txv_t;

  // expected frames, in ring order; slot 2 carries end-of-list
  localparam txv_t TXV [3] = '{
    '{32'h8000_00A5, 16'h0040, 32'h0000_1000},
    '{32'h8000_0011, 16'h05EE, 32'h0000_2004},
    '{32'hC000_0022, 16'h003C, 32'h0000_3008}
  };

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] tx_base = '0, tx_last = '0, rx_base = '0, rx_last = '0;
  logic          tx_start = 1'b0, tx_run, tx_fv, tx_fr = 1'b0;
  logic [31:0]   tx_fa;
  logic [15:0]   tx_fl;
  logic          rx_en = 1'b0, rx_fv = 1'b0, rx_fe = 1'b0, rx_fr, rx_done, rx_err;
  logic [15:0]   rx_fl = '0, rx_len;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;

  int checks = 0, errors = 0;
  int n_acc = 0, n_wr = 0, busy = 0, overlap = 0;

  always #4 clk = ~clk;

  eth_desc_walker #(.AW(AW), .MEM_LAT(LAT)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_base_i(tx_base), .tx_last_i(tx_last), .tx_start_i(tx_start), .tx_run_o(tx_run),
    .tx_frm_valid_o(tx_fv), .tx_frm_addr_o(tx_fa), .tx_frm_len_o(tx_fl), .tx_frm_ready_i(tx_fr),
    .rx_base_i(rx_base), .rx_last_i(rx_last), .rx_en_i(rx_en),
    .rx_frm_valid_i(rx_fv), .rx_frm_len_i(rx_fl), .rx_frm_err_i(rx_fe), .rx_frm_ready_o(rx_fr),
    .rx_done_o(rx_done), .rx_len_o(rx_len), .rx_err_o(rx_err),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  logic [31:0] mem  [64];
  logic [31:0] pipe [LAT];
  assign mem_rdata = pipe[LAT-1];

  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
    pipe[0] <= mem[mem_addr[7:2]];
    for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
  end

  // port monitor for R11
  always @(posedge clk) begin
    if (rst_n) begin
      if (mem_req) begin
        n_acc++;
        if (mem_we) n_wr++;
        if (busy != 0) overlap++;
      end
      if (mem_req && !mem_we) busy = LAT - 1;
      else if (busy != 0) busy--;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [31:0] v);
    mem[a[7:2]] <= v;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
  endtask

  task automatic tx_take(input string tag, input logic [31:0] ea, input logic [15:0] el);
    int n = 0;
    while (!tx_fv && n < 300) begin @(negedge clk); n++; end
    check({tag, " frame offered"}, 32'(tx_fv), 32'd1);
    check({tag, " addr"}, tx_fa, ea);
    check({tag, " len"}, 32'(tx_fl), 32'(el));
    repeat (2) @(negedge clk);
    check({tag, " held"}, {tx_fv, tx_fl, tx_fa[14:0]}, {1'b1, el, ea[14:0]});
    tx_fr = 1'b1;
    @(negedge clk);
    tx_fr = 1'b0;
  endtask

  task automatic wait_stop();
    int n = 0;
    while (tx_run && n < 300) begin @(negedge clk); n++; end
  endtask

  task automatic rx_frame(input string tag, input logic [15:0] l, input logic e,
                          input logic [15:0] el, input logic ee);
    int n = 0;
    rx_fv = 1'b1; rx_fl = l; rx_fe = e;
    @(negedge clk);
    while (!rx_fr && n < 300) begin @(negedge clk); n++; end
    @(negedge clk);
    rx_fv = 1'b0; rx_fe = 1'b0;
    n = 0;
    while (!rx_done && n < 300) begin @(negedge clk); n++; end
    check({tag, " R10 done"}, 32'(rx_done), 32'd1);
    check({tag, " R10 len"}, 32'(rx_len), 32'(el));
    check({tag, " R10 err"}, 32'(rx_err), 32'(ee));
    @(negedge clk);
    check({tag, " R10 pulse width"}, 32'(rx_done), 32'd0);
  endtask

  initial begin
    int snap;
    bit  seen;
    for (int i = 0; i < 64; i++) mem[i] <= '0;
    tx_base = 16'h0000; tx_last = 16'h0030;
    rx_base = 16'h0080; rx_last = 16'h00B0;
    repeat (3) @(negedge clk);
    check("R5 reset run", 32'(tx_run), 32'd0);
    check("R2 reset offer", 32'(tx_fv), 32'd0);
    check("R10 reset done", 32'(rx_done), 32'd0);
    check("R11 reset port", 32'(mem_req), 32'd0);
    rst_n = 1'b1;

    for (int k = 0; k < 3; k++) begin
      poke(8'(k * 16), TXV[k].ctrl);
      poke(8'(k * 16 + 4), {TXV[k].len, 16'h0});
      poke(8'(k * 16 + 8), TXV[k].addr);
    end
    poke(8'h30, 32'h8000_0033);
    poke(8'h34, 32'h0100_0000);
    poke(8'h38, 32'h0000_4000);

    pulse_start();
    check("R5 run after start", 32'(tx_run), 32'd1);
    for (int k = 0; k < 3; k++) tx_take("R2 ring", TXV[k].addr, TXV[k].len);
    wait_stop();
    check("R1 stop on unowned", 32'(tx_run), 32'd0);
    snap = n_acc;
    repeat (20) @(negedge clk);
    check("R1 no access after stop", 32'(n_acc), 32'(snap));
    check("R3 wb slot0", mem[0], TXV[0].ctrl & 32'h7FFF_FFFF);
    check("R3 wb slot2 keeps eol", mem[8], TXV[2].ctrl & 32'h7FFF_FFFF);
    check("R4 eol skips slot3", mem[12], 32'h8000_0033);

    // restart resumes at slot 0, stops at unowned slot 1
    poke(8'h00, 32'h8000_0044);
    pulse_start();
    tx_take("R5 resume", 32'h0000_1000, 16'h0040);
    wait_stop();
    check("R5 stopped again", 32'(tx_run), 32'd0);
    check("R3 wb resume", mem[0], 32'h0000_0044);

    // wrap on last-slot address
    tx_last = 16'h0010;
    poke(8'h10, 32'h8000_0055);
    poke(8'h00, 32'h8000_0066);
    pulse_start();
    tx_take("R4 last slot", 32'h0000_2004, 16'h05EE);
    tx_take("R4 wrap to base", 32'h0000_1000, 16'h0040);
    wait_stop();
    check("R4 slot2 untouched", mem[8], 32'h4000_0022);

    // receive ring
    poke(8'h80, 32'h8800_0001); poke(8'h84, 32'h0600_0000);
    poke(8'h90, 32'h8000_0002); poke(8'h94, 32'h0600_0000);
    poke(8'hA0, 32'h8000_0003); poke(8'hA4, 32'h0080_0000);
    poke(8'hB0, 32'h0000_0004); poke(8'hB4, 32'h0600_0000);

    rx_fv = 1'b1; rx_fl = 16'h0040;
    snap = n_acc; seen = 1'b0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (rx_fr) seen = 1'b1; end
    check("R6 no accept when off", 32'(seen), 32'd0);
    check("R6 no access when off", 32'(n_acc), 32'(snap));
    rx_fv = 1'b0;

    rx_en = 1'b1;
    rx_frame("clean", 16'h0100, 1'b0, 16'h0100, 1'b0);
    check("R7 len stored", mem[33], 32'h0600_0100);
    check("R8 stale err cleared", mem[32], 32'h0000_0001);
    rx_frame("oversize", 16'h0700, 1'b0, 16'h0600, 1'b1);
    check("R7 clipped", mem[37], 32'h0600_0600);
    check("R8 overflow err", mem[36], 32'h0800_0002);
    rx_frame("bad", 16'h0020, 1'b1, 16'h0020, 1'b1);
    check("R8 input err", mem[40], 32'h0800_0003);
    check("R7 small buf", mem[41], 32'h0080_0020);

    // unowned receive slot holds the frame back
    rx_fv = 1'b1; rx_fl = 16'h0055; rx_fe = 1'b0;
    snap = n_wr; seen = 1'b0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (rx_fr) seen = 1'b1; end
    check("R9 not accepted", 32'(seen), 32'd0);
    check("R9 no writes", 32'(n_wr), 32'(snap));
    check("R9 slot intact", mem[44], 32'h0000_0004);
    rx_fv = 1'b0;
    poke(8'hB0, 32'hC000_0004);
    rx_frame("R9 retry", 16'h0055, 1'b0, 16'h0055, 1'b0);
    check("R8 eol kept", mem[44], 32'h4000_0004);
    poke(8'h80, 32'h8000_0009);
    rx_frame("R4 rx wrap", 16'h0010, 1'b0, 16'h0010, 1'b0);
    check("R4 rx wrap slot", mem[33], 32'h0600_0010);

    check("R11 no overlap", 32'(overlap), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule